// File: doc/BRIEF.md
# Successive-Integration Conversion Sequencer

This block is the digital controller of an integrating A/D converter. It refines the classic integrate/deintegrate cycle with residue-correction rounds. It runs on the converter clock, which is half the oscillator rate. It reads four inputs: a zero-crossing bit from the analog comparator, the input polarity, a range select and an external hold control. From these it drives one control line for each analog switch, a count enable and a count direction for an external up/down results counter, and an active-low latch strobe for the display latches.

A conversion is made of two passes. The first pass measures the input. The second pass repeats the same sequence with the inputs shorted inside the analog section, so that the amplifier offset is measured. During the second pass the counter direction is inverted, so the offset reading is subtracted from the result digitally. Each pass runs a fixed-length integrate phase and then three deintegrate phases. Between the deintegrate phases come a settling rest and a ×10 residue gain step. The deintegrate count direction alternates: up, down, up. A deintegrate phase that sees no zero crossing is cut off by a timeout, which raises an overflow flag. All phase lengths are parameters. The integrate length is picked at run time by the range input.

Top module: `sis_conv_seq`

## Requirements
- R1: While synchronous reset (rst_n low) is applied and on the first cycle after it, the block is in the zero-integrate phase of the first pass: phase_o = 0, pass_o = 0, only sw_zi_o is high among the switch outputs, cnt_en_o = 0, cnt_up_o = 0, ovf_o = 0 and latch_n_o = 1.
- R2: phase_o reports the phase with these codes: zero-integrate 0, integrate 1, first deintegrate 2, rest 3, ×10 4, second deintegrate 5, rest 6, ×10 7, third deintegrate 8, latch 9. Within one pass the phases follow the numeric order from 0 to 8.
- R3: The integrate phase lasts HI_INT_LEN cycles when range_hi_i = 1 and LO_INT_LEN cycles when range_hi_i = 0. range_hi_i is sampled on the edge that enters the integrate phase.
- R4: The zero-integrate phase lasts ZI_LEN cycles, each rest phase lasts REST_LEN cycles, and each ×10 phase lasts X10_LEN cycles.
- R5: A deintegrate phase ends on the first clock edge at which zc_i is sampled high. Its length is the number of its cycles up to and including that one.
- R6: cnt_en_o is high on every cycle of a deintegrate phase and low at all other times. cnt_up_o is 1 in phases 2 and 8 and 0 in phase 5 while pass_o = 0. The polarity is inverted while pass_o = 1. cnt_up_o is 0 outside deintegrate phases.
- R7: pol_i is sampled on the edge that leaves the integrate phase. In every deintegrate phase, sw_ref_pos_o is high if the sample was 1 and sw_ref_neg_o is high if it was 0. Both are low in all other phases.
- R8: On every cycle exactly one switch output is high. sw_int1_o is high in phase 1 with pass_o = 0 and sw_int2_o in phase 1 with pass_o = 1. sw_rest_o is high in phases 3 and 6, sw_x10_o in phases 4 and 7, and sw_zi_o in phases 0 and 9.
- R9: After phase 8 of the first pass, the block enters phase 0 with pass_o = 1 and runs phases 0 to 8 again. After phase 8 of the second pass it enters the latch phase 9, which lasts LATCH_LEN cycles. It then returns to phase 0 with pass_o = 0.
- R10: With hold_i low, latch_n_o is low on every cycle of the latch phase and high on every other cycle.
- R11: With hold_i high, latch_n_o stays high, the latch phase included.
- R12: A deintegrate phase that reaches DE_TIMEOUT cycles without a zero crossing ends after exactly DE_TIMEOUT cycles and sets ovf_o. ovf_o stays set until the edge that enters the integrate phase of the next first pass. A crossing on the final allowed cycle does not set ovf_o.
- R13: zc_i has no effect outside deintegrate phases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Synchronous reset, active low |
| zc_i | input | 1 | Comparator reports integrator zero crossing |
| pol_i | input | 1 | Input polarity, 1 = positive |
| range_hi_i | input | 1 | 1 selects the short (high-range) integrate time |
| hold_i | input | 1 | External hold; high suppresses the latch strobe |
| phase_o | output | 4 | Current phase code |
| pass_o | output | 1 | 0 = input pass, 1 = offset pass |
| sw_int1_o | output | 1 | Input-integrate switch control |
| sw_int2_o | output | 1 | Shorted-input integrate switch control |
| sw_ref_pos_o | output | 1 | Positive-reference deintegrate switch |
| sw_ref_neg_o | output | 1 | Negative-reference deintegrate switch |
| sw_rest_o | output | 1 | Rest switch control |
| sw_x10_o | output | 1 | ×10 residue gain switch control |
| sw_zi_o | output | 1 | Zero-integrate switch control |
| cnt_en_o | output | 1 | Results counter enable |
| cnt_up_o | output | 1 | Results counter direction, 1 = up |
| latch_n_o | output | 1 | Display latch strobe, active low |
| ovf_o | output | 1 | Deintegrate timeout flag |

## Verification
The hardest cases to reach are the deintegrate endings that depend on timing: a crossing on the very first cycle, a crossing on exactly the last allowed cycle, and a real timeout, each in a known pass and phase. The bench models the comparator with a queue of scripted crossing cycles, one entry per deintegrate phase. It raises zc_i on the chosen cycle of each phase. A value of zero means the crossing never comes. In one conversion it also holds zc_i high outside the deintegrate phases, so that stray crossings are shown to have no effect.

// File: rtl/sis_pkg.sv
package sis_pkg;

    typedef enum logic [3:0] {
        PH_ZI    = 4'd0,
        PH_INT   = 4'd1,
        PH_DE1   = 4'd2,
        PH_RST1  = 4'd3,
        PH_X1    = 4'd4,
        PH_DE2   = 4'd5,
        PH_RST2  = 4'd6,
        PH_X2    = 4'd7,
        PH_DE3   = 4'd8,
        PH_LATCH = 4'd9
    } phase_e;

    typedef struct packed {
        phase_e ph;
        logic   pass;
        logic   rng;
        logic   pol;
        logic   ovf;
    } seq_st_t;

    function automatic logic is_de(input phase_e p);
        return (p == PH_DE1) || (p == PH_DE2) || (p == PH_DE3);
    endfunction

endpackage

// File: rtl/sis_len_sel.sv
module sis_len_sel
    import sis_pkg::*;
#(
    parameter int unsigned LO_INT_LEN = 10000,
    parameter int unsigned HI_INT_LEN = 1000,
    parameter int unsigned REST_LEN   = 100,
    parameter int unsigned X10_LEN    = 100,
    parameter int unsigned ZI_LEN     = 100,
    parameter int unsigned LATCH_LEN  = 100,
    parameter int unsigned DE_TIMEOUT = 20000,
    parameter int unsigned CW         = 15
) (
    input  phase_e          ph_i,
    input  logic            rng_i,
    output logic [CW-1:0]   last_o
);
    localparam logic [CW-1:0] LO_LAST  = CW'(LO_INT_LEN - 1);
    localparam logic [CW-1:0] HI_LAST  = CW'(HI_INT_LEN - 1);
    localparam logic [CW-1:0] RST_LAST = CW'(REST_LEN - 1);
    localparam logic [CW-1:0] X_LAST   = CW'(X10_LEN - 1);
    localparam logic [CW-1:0] ZI_LAST  = CW'(ZI_LEN - 1);
    localparam logic [CW-1:0] LAT_LAST = CW'(LATCH_LEN - 1);
    localparam logic [CW-1:0] DE_LAST  = CW'(DE_TIMEOUT - 1);

    always_comb begin
        case (ph_i)
            PH_ZI:            last_o = ZI_LAST;
            PH_INT:           last_o = rng_i ? HI_LAST : LO_LAST;
            PH_RST1, PH_RST2: last_o = RST_LAST;
            PH_X1, PH_X2:     last_o = X_LAST;
            PH_LATCH:         last_o = LAT_LAST;
            default:          last_o = DE_LAST;
        endcase
    end
endmodule

// File: rtl/sis_timer.sv
module sis_timer #(
    parameter int unsigned CW = 15
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic [CW-1:0] last_i,
    output logic          done_o
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d  = clr_i ? '0 : cnt_q + CW'(1);
        done_o = (cnt_q == last_i);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R4
    timer_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= last_i);
endmodule

// File: rtl/sis_sw_dec.sv
module sis_sw_dec
    import sis_pkg::*;
(
    input  phase_e ph_i,
    input  logic   pass_i,
    input  logic   pol_i,
    output logic   int1_o,
    output logic   int2_o,
    output logic   ref_pos_o,
    output logic   ref_neg_o,
    output logic   rest_o,
    output logic   x10_o,
    output logic   zi_o,
    output logic   cnt_en_o,
    output logic   cnt_up_o
);
    logic de;

    always_comb begin
        de        = is_de(ph_i);
        int1_o    = (ph_i == PH_INT) && !pass_i;
        int2_o    = (ph_i == PH_INT) &&  pass_i;
        ref_pos_o = de &&  pol_i;
        ref_neg_o = de && !pol_i;
        rest_o    = (ph_i == PH_RST1) || (ph_i == PH_RST2);
        x10_o     = (ph_i == PH_X1)   || (ph_i == PH_X2);
        zi_o      = (ph_i == PH_ZI)   || (ph_i == PH_LATCH);
        cnt_en_o  = de;
        cnt_up_o  = de && ((ph_i != PH_DE2) ^ pass_i);
    end
endmodule

// File: rtl/sis_conv_seq.sv
module sis_conv_seq
    import sis_pkg::*;
#(
    parameter int unsigned LO_INT_LEN = 10000,
    parameter int unsigned HI_INT_LEN = 1000,
    parameter int unsigned REST_LEN   = 100,
    parameter int unsigned X10_LEN    = 100,
    parameter int unsigned ZI_LEN     = 100,
    parameter int unsigned LATCH_LEN  = 100,
    parameter int unsigned DE_TIMEOUT = 20000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       zc_i,
    input  logic       pol_i,
    input  logic       range_hi_i,
    input  logic       hold_i,
    output logic [3:0] phase_o,
    output logic       pass_o,
    output logic       sw_int1_o,
    output logic       sw_int2_o,
    output logic       sw_ref_pos_o,
    output logic       sw_ref_neg_o,
    output logic       sw_rest_o,
    output logic       sw_x10_o,
    output logic       sw_zi_o,
    output logic       cnt_en_o,
    output logic       cnt_up_o,
    output logic       latch_n_o,
    output logic       ovf_o
);
    localparam int unsigned MAX_A  = (LO_INT_LEN > HI_INT_LEN) ? LO_INT_LEN : HI_INT_LEN;
    localparam int unsigned MAX_B  = (DE_TIMEOUT > MAX_A) ? DE_TIMEOUT : MAX_A;
    localparam int unsigned MAX_C  = (REST_LEN > X10_LEN) ? REST_LEN : X10_LEN;
    localparam int unsigned MAX_D  = (ZI_LEN > LATCH_LEN) ? ZI_LEN : LATCH_LEN;
    localparam int unsigned MAX_E  = (MAX_C > MAX_D) ? MAX_C : MAX_D;
    localparam int unsigned MAXLEN = (MAX_B > MAX_E) ? MAX_B : MAX_E;
    localparam int unsigned CW     = $clog2(MAXLEN + 1);

    seq_st_t        st_d, st_q;
    logic [CW-1:0]  last;
    logic           tmr_done;
    logic           de;
    logic           adv;

    sis_len_sel #(
        .LO_INT_LEN (LO_INT_LEN),
        .HI_INT_LEN (HI_INT_LEN),
        .REST_LEN   (REST_LEN),
        .X10_LEN    (X10_LEN),
        .ZI_LEN     (ZI_LEN),
        .LATCH_LEN  (LATCH_LEN),
        .DE_TIMEOUT (DE_TIMEOUT),
        .CW         (CW)
    ) u_len (
        .ph_i   (st_q.ph),
        .rng_i  (st_q.rng),
        .last_o (last)
    );

    sis_timer #(.CW(CW)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (adv),
        .last_i (last),
        .done_o (tmr_done)
    );

    sis_sw_dec u_dec (
        .ph_i      (st_q.ph),
        .pass_i    (st_q.pass),
        .pol_i     (st_q.pol),
        .int1_o    (sw_int1_o),
        .int2_o    (sw_int2_o),
        .ref_pos_o (sw_ref_pos_o),
        .ref_neg_o (sw_ref_neg_o),
        .rest_o    (sw_rest_o),
        .x10_o     (sw_x10_o),
        .zi_o      (sw_zi_o),
        .cnt_en_o  (cnt_en_o),
        .cnt_up_o  (cnt_up_o)
    );

    always_comb begin
        st_d = st_q;
        de   = is_de(st_q.ph);
        adv  = tmr_done || (de && zc_i);
        if (de && tmr_done && !zc_i) st_d.ovf = 1'b1;
        if (adv) begin
            case (st_q.ph)
                PH_ZI: begin
                    st_d.ph  = PH_INT;
                    st_d.rng = range_hi_i;
                    if (!st_q.pass) st_d.ovf = 1'b0;
                end
                PH_INT: begin
                    st_d.ph  = PH_DE1;
                    st_d.pol = pol_i;
                end
                PH_DE1:  st_d.ph = PH_RST1;
                PH_RST1: st_d.ph = PH_X1;
                PH_X1:   st_d.ph = PH_DE2;
                PH_DE2:  st_d.ph = PH_RST2;
                PH_RST2: st_d.ph = PH_X2;
                PH_X2:   st_d.ph = PH_DE3;
                PH_DE3: begin
                    if (st_q.pass) begin
                        st_d.ph = PH_LATCH;
                    end else begin
                        st_d.ph   = PH_ZI;
                        st_d.pass = 1'b1;
                    end
                end
                PH_LATCH: begin
                    st_d.ph   = PH_ZI;
                    st_d.pass = 1'b0;
                end
                default: st_d.ph = PH_ZI;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.ph   <= PH_ZI;
            st_q.pass <= 1'b0;
            st_q.rng  <= 1'b0;
            st_q.pol  <= 1'b0;
            st_q.ovf  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase_o   = st_q.ph;
    assign pass_o    = st_q.pass;
    assign ovf_o     = st_q.ovf;
    assign latch_n_o = !((st_q.ph == PH_LATCH) && !hold_i);

    // R8
    one_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot({sw_int1_o, sw_int2_o, sw_ref_pos_o, sw_ref_neg_o,
                 sw_rest_o, sw_x10_o, sw_zi_o}));

    // R6
    cnt_in_de_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_en_o |-> (sw_ref_pos_o || sw_ref_neg_o));

    // R10
    latch_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !latch_n_o |-> (phase_o == 4'd9));

    // R12
    ovf_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_o) |-> $past(de));

    // R3
    rng_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ph == PH_INT && $past(st_q.ph) == PH_INT) |-> $stable(st_q.rng));

    // R9
    pass_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pass_o) |-> (phase_o == 4'd0 && $past(phase_o) == 4'd8));
endmodule

// File: tb/sis_conv_seq_tb.sv
`timescale 1ns/1ps
module sis_conv_seq_tb;
    localparam int P_LO  = 200;
    localparam int P_HI  = 20;
    localparam int P_RST = 6;
    localparam int P_X10 = 5;
    localparam int P_ZI  = 8;
    localparam int P_LAT = 10;
    localparam int P_TO  = 50;
    localparam int WD    = 20000;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n, zc_i, pol_i, range_hi_i, hold_i;
    logic [3:0] phase_o;
    logic pass_o, sw_int1_o, sw_int2_o, sw_ref_pos_o, sw_ref_neg_o;
    logic sw_rest_o, sw_x10_o, sw_zi_o, cnt_en_o, cnt_up_o, latch_n_o, ovf_o;

    sis_conv_seq #(
        .LO_INT_LEN(P_LO), .HI_INT_LEN(P_HI), .REST_LEN(P_RST), .X10_LEN(P_X10),
        .ZI_LEN(P_ZI), .LATCH_LEN(P_LAT), .DE_TIMEOUT(P_TO)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .zc_i(zc_i), .pol_i(pol_i),
        .range_hi_i(range_hi_i), .hold_i(hold_i), .phase_o(phase_o),
        .pass_o(pass_o), .sw_int1_o(sw_int1_o), .sw_int2_o(sw_int2_o),
        .sw_ref_pos_o(sw_ref_pos_o), .sw_ref_neg_o(sw_ref_neg_o),
        .sw_rest_o(sw_rest_o), .sw_x10_o(sw_x10_o), .sw_zi_o(sw_zi_o),
        .cnt_en_o(cnt_en_o), .cnt_up_o(cnt_up_o), .latch_n_o(latch_n_o),
        .ovf_o(ovf_o)
    );

    typedef struct { int ph; int pss; int len; int ovf; int lat; } item_t;
    typedef struct { int rng; int pol; int hold; int noise; } cfg_t;

    item_t exp_q[$];
    cfg_t  cfg_q[$];
    int    k_q[$];
    int    errs = 0, checks = 0;
    int    ovf_model = 0;
    int    noise = 0, cur_pol = 0, cur_hold = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    task automatic push_item(input int ph, input int pss, input int len,
                             input int ovf, input int lat);
        item_t it;
        it.ph = ph; it.pss = pss; it.len = len; it.ovf = ovf; it.lat = lat;
        exp_q.push_back(it);
    endtask

    // driver: queues one conversion and its expected phase runs
    task automatic queue_conv(input int rng, input int pol, input int hold,
                              input int nz, input int ks[6]);
        cfg_t c;
        c.rng = rng; c.pol = pol; c.hold = hold; c.noise = nz;
        cfg_q.push_back(c);
        push_item(0, 0, P_ZI, ovf_model, 0);
        for (int p = 0; p < 2; p++) begin
            if (p == 1) push_item(0, 1, P_ZI, ovf_model, 0);
            if (p == 0) ovf_model = 0;
            push_item(1, p, rng ? P_HI : P_LO, ovf_model, 0);
            for (int j = 0; j < 3; j++) begin
                int k;
                bit to;
                k  = ks[p*3 + j];
                to = (k == 0) || (k > P_TO);
                k_q.push_back(k);
                push_item(j == 0 ? 2 : (j == 1 ? 5 : 8), p, to ? P_TO : k, ovf_model, 0);
                if (to) ovf_model = 1;
                if (j < 2) begin
                    push_item(j == 0 ? 3 : 6, p, P_RST, ovf_model, 0);
                    push_item(j == 0 ? 4 : 7, p, P_X10, ovf_model, 0);
                end
            end
        end
        push_item(9, 1, P_LAT, ovf_model, hold ? 0 : P_LAT);
    endtask

    task automatic apply_cfg();
        cfg_t c;
        c = cfg_q.pop_front();
        range_hi_i = c.rng[0];
        pol_i      = c.pol[0];
        hold_i     = c.hold[0];
        noise      = c.noise;
        cur_pol    = c.pol;
        cur_hold   = c.hold;
    endtask

    function automatic bit de_code(input int p);
        return (p == 2) || (p == 5) || (p == 8);
    endfunction

    // monitor + comparator model
    initial begin : monitor
        int cur_ph, cur_pss, len, lat_low, last_ovf, cur_k, de_cyc, run_noise, ph, pss;
        int bad_sw, bad_ref, bad_cnt;
        cur_ph = -1; cur_pss = 0; len = 0; lat_low = 0; last_ovf = 0;
        cur_k = 0; de_cyc = 0; run_noise = 0;
        bad_sw = 0; bad_ref = 0; bad_cnt = 0;
        forever begin
            @(negedge clk);
            if (rst_n !== 1'b1) continue;
            ph  = int'(phase_o);
            pss = int'(pass_o);
            if (ph != cur_ph || pss != cur_pss) begin
                if (cur_ph >= 0 && exp_q.size() > 0) begin
                    item_t e;
                    string lt;
                    e = exp_q.pop_front();
                    chk(cur_ph == e.ph && cur_pss == e.pss, "R2/R9", "phase*2+pass",
                        cur_ph*2 + cur_pss, e.ph*2 + e.pss);
                    if (run_noise != 0 && !de_code(e.ph)) lt = "R13";
                    else if (e.ph == 1) lt = "R3";
                    else if (de_code(e.ph)) lt = (e.len == P_TO) ? "R12" : "R5";
                    else if (e.ph == 9) lt = "R9";
                    else lt = "R4";
                    chk(len == e.len, lt, "run length", len, e.len);
                    chk(last_ovf == e.ovf, "R12", "ovf", last_ovf, e.ovf);
                    chk(lat_low == e.lat, (e.ph == 9 && e.lat == 0) ? "R11" : "R10",
                        "latch low cycles", lat_low, e.lat);
                    chk(bad_sw == 0, "R8", "switch mismatch cycles", bad_sw, 0);
                    chk(bad_ref == 0, "R7", "reference switch mismatch cycles", bad_ref, 0);
                    chk(bad_cnt == 0, "R6", "count strobe mismatch cycles", bad_cnt, 0);
                end
                if (ph == 0 && pss == 0 && cur_ph >= 0 && cfg_q.size() > 0) apply_cfg();
                cur_ph = ph; cur_pss = pss; len = 0; lat_low = 0;
                bad_sw = 0; bad_ref = 0; bad_cnt = 0; run_noise = noise;
                if (de_code(ph)) begin
                    cur_k  = (k_q.size() > 0) ? k_q.pop_front() : 0;
                    de_cyc = 0;
                end
            end
            len++;
            if (latch_n_o == 1'b0) lat_low++;
            last_ovf = int'(ovf_o);
            begin
                bit isde;
                logic [4:0] e_sw;
                isde = de_code(ph);
                e_sw = {ph == 1 && pss == 0, ph == 1 && pss == 1, ph == 3 || ph == 6,
                        ph == 4 || ph == 7, ph == 0 || ph == 9};
                if ({sw_int1_o, sw_int2_o, sw_rest_o, sw_x10_o, sw_zi_o} !== e_sw) bad_sw++;
                if (sw_ref_pos_o !== (isde && cur_pol != 0) ||
                    sw_ref_neg_o !== (isde && cur_pol == 0)) bad_ref++;
                if (cnt_en_o !== isde ||
                    cnt_up_o !== (isde && ((ph != 5) ^ (pss != 0)))) bad_cnt++;
                if (isde) begin
                    de_cyc++;
                    zc_i = (de_cyc == cur_k);
                end else begin
                    zc_i = (noise != 0);
                end
            end
        end
    end

    initial begin : main
        int cyc;
        rst_n = 1'b0; zc_i = 1'b0; pol_i = 1'b0; range_hi_i = 1'b0; hold_i = 1'b0;
        // R3 R5 R7: low range, positive input, ordinary crossings
        queue_conv(0, 1, 0, 0, '{30, 12, 7, 25, 3, 9});
        // R13: stray crossings outside deintegrate; R5 first-cycle crossing
        queue_conv(1, 0, 0, 1, '{1, 1, 2, 40, 5, 6});
        // R11 hold, R12 timeout in first deintegrate
        queue_conv(1, 1, 1, 0, '{0, 4, 4, 5, 5, 5});
        // R12: crossing exactly on the last allowed cycle, flag cleared
        queue_conv(0, 0, 0, 0, '{P_TO, 2, 3, 4, 5, 6});
        // R12: timeout in the last deintegrate of the offset pass
        queue_conv(1, 1, 0, 0, '{49, 10, 10, 10, 10, 0});
        apply_cfg();
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(phase_o == 4'd0, "R1", "phase in reset", int'(phase_o), 0);
        chk(pass_o == 1'b0, "R1", "pass in reset", int'(pass_o), 0);
        chk({sw_int1_o, sw_int2_o, sw_ref_pos_o, sw_ref_neg_o, sw_rest_o, sw_x10_o, sw_zi_o}
            == 7'b0000001, "R1", "switches in reset",
            int'({sw_int1_o, sw_int2_o, sw_ref_pos_o, sw_ref_neg_o, sw_rest_o, sw_x10_o, sw_zi_o}), 1);
        chk(cnt_en_o == 1'b0 && cnt_up_o == 1'b0, "R1", "count strobes in reset",
            int'({cnt_en_o, cnt_up_o}), 0);
        chk(latch_n_o == 1'b1 && ovf_o == 1'b0, "R1", "latch/ovf in reset",
            int'({latch_n_o, ovf_o}), 2);
        @(posedge clk);
        #1 rst_n = 1'b1;
        cyc = 0;
        while (exp_q.size() > 0 && cyc < WD) begin
            @(posedge clk);
            cyc++;
        end
        if (exp_q.size() > 0) begin
            checks++;
            errs++;
            $display("FAIL R2 watchdog: actual=%0d expected=0 pending runs", exp_q.size());
        end
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule